// File: doc/BRIEF.md
# Multi-Drop Receive Mute Controller

This block sits after a UART receive deserializer on a node of a multi-drop serial network. It decides which received characters reach the host. It is fed a one-cycle strobe for each completed byte and another for each idle frame detected on the line. From these it keeps a mute state. While the node is muted, received traffic is discarded and no receive flag or interrupt is produced. The node therefore only spends host effort on messages addressed to it.

Two wake methods are selectable. In idle-line mode, software mutes the node and the next idle frame wakes it. In address-mark mode, a byte with its most significant bit set is an address. Its low four bits select a node. A mismatch mutes the receiver and a match wakes it. The host sees a data-ready flag with the held byte, an idle flag and a single gated interrupt request.

Top module: `mpx_mute_ctrl`

## Requirements
- R1: After reset, `mute`, `rx_ready`, `idle_flag` and `rx_irq` are all 0.
- R2: A pulse on `mute_wr` loads `mute_wdata` into `mute` at the next clock edge, in either wake mode, unless a hardware update from a received event occurs in the same cycle.
- R3: While `mute` is 1, neither `rx_ready` nor `idle_flag` can become set. Flags already set stay as they were. `rx_irq` is held at 0 even if a flag is pending.
- R4: With `wake_sel` = 0 (idle-line mode), an `idle_det` pulse while muted clears `mute` at the next edge, and `idle_flag` is not set by that pulse.
- R5: While unmuted, a `rx_valid` pulse sets `rx_ready` and loads `rx_data` with the byte at the next edge. A `data_read` pulse clears `rx_ready`. A new byte in the same cycle as `data_read` wins, and `rx_ready` stays 1 with the new byte.
- R6: While unmuted, an `idle_det` pulse sets `idle_flag` at the next edge. An `idle_ack` pulse clears it.
- R7: With `wake_sel` = 1, a byte with bit 7 = 1 is an address byte, and its bits 3:0 are compared with `node_addr`. On a mismatch, `mute` is 1 after the next edge and the byte is not delivered, whether or not the node was muted.
- R8: With `wake_sel` = 1, an address byte whose bits 3:0 equal `node_addr` clears `mute` if it was set. The byte itself is delivered, so `rx_ready` = 1 and `rx_data` equals the byte.
- R9: While muted, bytes that do not wake the node are dropped. This covers every byte in idle-line mode and every byte with bit 7 = 0 in address-mark mode. `rx_data` keeps its previous value.
- R10: A hardware clear of `mute` caused by a received event wins over a software write of 1 in the same cycle.
- R11: `rx_irq` equals `irq_en` AND NOT `mute` AND (`rx_ready` OR `idle_flag`).
- R12: With `wake_sel` = 0, bit 7 of a byte has no special meaning: an unmuted node delivers every one of the 256 byte values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte was received |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| idle_det | input | 1 | One-cycle strobe: an idle frame was seen |
| mute_wr | input | 1 | Software write strobe for the mute bit |
| mute_wdata | input | 1 | Value written to the mute bit |
| wake_sel | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| node_addr | input | 4 | This node's address |
| data_read | input | 1 | Host read of the data register, clears `rx_ready` |
| idle_ack | input | 1 | Host acknowledge, clears `idle_flag` |
| irq_en | input | 1 | Receive interrupt enable |
| mute | output | 1 | Current mute state |
| rx_ready | output | 1 | Received byte available |
| rx_data | output | 8 | Last delivered byte |
| idle_flag | output | 1 | Idle frame seen while unmuted |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Every stimulus is consumed at one rising edge. `mute`, `rx_ready`, `rx_data` and `idle_flag` take their new values at that same edge, one cycle after the input was presented. `rx_irq` is a combinational function of those registers and follows them without further delay. The bench drives inputs just after an edge and holds them for exactly one cycle. It samples all outputs one time unit after the following edge, so each check lands on the first cycle in which its result is due. Address matching is swept over every pair of node address and received low nibble. Data delivery is swept over all 256 byte values.

// File: rtl/mpx_pkg.sv
// Package: shared types for the multi-drop mute controller.
// Assumes nothing beyond a 1-bit wake-method select.
package mpx_pkg;

    // Wake method selected by software.
    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_e;

endpackage

// File: rtl/mpx_addr_decode.sv
// Module: mpx_addr_decode
// Classifies a received byte as an address byte and compares its
// node field with the programmed node address. Purely combinational.
// Assumes the address marker is the byte's MSB and that the node field
// occupies the ADDR_W least significant bits.
module mpx_addr_decode
    import mpx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] node_addr,
    input  wake_e             wake,
    output logic              is_addr,
    output logic              addr_hit
);

    localparam int unsigned MARK_BIT = DATA_W - 1;

    // Address marker only has meaning in address-mark mode.
    always_comb begin
        is_addr  = (wake == WAKE_ADDR) && rx_byte[MARK_BIT];
        addr_hit = (rx_byte[ADDR_W-1:0] == node_addr);
    end

endmodule

// File: rtl/mpx_mute_fsm.sv
// Module: mpx_mute_fsm
// Holds the mute state and decides whether each received event is
// passed on to the host flags. Hardware events from the line take
// priority over software writes in the same cycle.
// Assumes rx_valid and idle_det are single-cycle strobes.
module mpx_mute_fsm
    import mpx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_valid,
    input  logic  idle_det,
    input  logic  is_addr,
    input  logic  addr_hit,
    input  wake_e wake,
    input  logic  mute_wr,
    input  logic  mute_wdata,
    output logic  mute,
    output logic  deliver,
    output logic  idle_evt
);

    logic idle_wake;
    logic addr_wake;
    logic addr_drop;
    logic hw_clr;

    // Classify this cycle's line events against the current mute state.
    always_comb begin
        idle_wake = mute && (wake == WAKE_IDLE) && idle_det;
        addr_wake = mute && rx_valid && is_addr && addr_hit;
        addr_drop = rx_valid && is_addr && !addr_hit;
        hw_clr    = idle_wake || addr_wake;
        deliver   = rx_valid && !addr_drop && (!mute || addr_wake);
        idle_evt  = idle_det && !mute;
    end

    // Mute register: hardware clear, then hardware set, then software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute <= 1'b0;
        end else if (hw_clr) begin
            mute <= 1'b0;
        end else if (addr_drop) begin
            mute <= 1'b1;
        end else if (mute_wr) begin
            mute <= mute_wdata;
        end
    end

endmodule

// File: rtl/mpx_flag_unit.sv
// Module: mpx_flag_unit
// Host-visible receive flags and data holding register. A set request
// wins over a clear request arriving in the same cycle.
// Assumes deliver and idle_evt are already gated by the mute state.
module mpx_flag_unit #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              idle_evt,
    input  logic              data_read,
    input  logic              idle_ack,
    output logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              idle_flag
);

    // Data-ready flag: set on delivery, cleared by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ready <= 1'b0;
        end else if (deliver) begin
            rx_ready <= 1'b1;
        end else if (data_read) begin
            rx_ready <= 1'b0;
        end
    end

    // Data holding register: loaded only by a delivered byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (deliver) begin
            rx_data <= rx_byte;
        end
    end

    // Idle flag: set on an unmuted idle frame, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_flag <= 1'b0;
        end else if (idle_evt) begin
            idle_flag <= 1'b1;
        end else if (idle_ack) begin
            idle_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/mpx_mute_ctrl.sv
// Module: mpx_mute_ctrl (top)
// Receive-side mute controller for a multi-drop serial node. Gates
// received bytes and idle frames with a mute state that is left either
// on an idle frame or on a matching address byte.
// Assumes a deserializer upstream that produces one-cycle strobes.
module mpx_mute_ctrl
    import mpx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              idle_det,
    input  logic              mute_wr,
    input  logic              mute_wdata,
    input  logic              wake_sel,
    input  logic [ADDR_W-1:0] node_addr,
    input  logic              data_read,
    input  logic              idle_ack,
    input  logic              irq_en,
    output logic              mute,
    output logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              idle_flag,
    output logic              rx_irq
);

    wake_e wake;
    logic  is_addr;
    logic  addr_hit;
    logic  deliver;
    logic  idle_evt;

    // Map the raw select onto the wake-method type.
    always_comb wake = wake_e'(wake_sel);

    mpx_addr_decode #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .rx_byte   (rx_byte),
        .node_addr (node_addr),
        .wake      (wake),
        .is_addr   (is_addr),
        .addr_hit  (addr_hit)
    );

    mpx_mute_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .idle_det   (idle_det),
        .is_addr    (is_addr),
        .addr_hit   (addr_hit),
        .wake       (wake),
        .mute_wr    (mute_wr),
        .mute_wdata (mute_wdata),
        .mute       (mute),
        .deliver    (deliver),
        .idle_evt   (idle_evt)
    );

    mpx_flag_unit #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .deliver   (deliver),
        .rx_byte   (rx_byte),
        .idle_evt  (idle_evt),
        .data_read (data_read),
        .idle_ack  (idle_ack),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .idle_flag (idle_flag)
    );

    // Interrupt request: any pending flag, enabled, and not muted.
    always_comb rx_irq = irq_en && !mute && (rx_ready || idle_flag);

endmodule

// File: rtl/mpx_mute_ctrl_chk.sv
// Module: mpx_mute_ctrl_chk
// Property checker for mpx_mute_ctrl, attached by bind below.
// Observes top-level ports only.
module mpx_mute_ctrl_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_byte,
    input logic              idle_det,
    input logic              mute_wr,
    input logic              mute_wdata,
    input logic              wake_sel,
    input logic [ADDR_W-1:0] node_addr,
    input logic              mute,
    input logic              rx_ready,
    input logic              idle_flag,
    input logic              rx_irq
);

    // R3: interrupt held off while muted.
    a_r3_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        mute |-> !rx_irq);

    // R3: no idle flag raised from a muted cycle.
    a_r3_no_idle_set: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> !$rose(idle_flag));

    // R9: idle-line mode while muted never delivers a byte.
    a_r9_idle_mode_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && !wake_sel) |=> !$rose(rx_ready));

    // R4: idle frame while muted in idle-line mode wakes the node.
    a_r4_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && !wake_sel && idle_det) |=> !mute);

    // R7: mismatching address byte mutes and is not delivered.
    a_r7_mismatch_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sel && rx_valid && rx_byte[DATA_W-1]
         && (rx_byte[ADDR_W-1:0] != node_addr)) |=> (mute && !$rose(rx_ready)));

    // R10: hardware wake wins over a software write of 1.
    a_r10_hw_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && !wake_sel && idle_det && mute_wr && mute_wdata) |=> !mute);

    // R2: software write with no line event lands next clock.
    a_r2_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_wr && !rx_valid && !idle_det) |=> (mute == $past(mute_wdata)));

endmodule

bind mpx_mute_ctrl mpx_mute_ctrl_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .idle_det   (idle_det),
    .mute_wr    (mute_wr),
    .mute_wdata (mute_wdata),
    .wake_sel   (wake_sel),
    .node_addr  (node_addr),
    .mute       (mute),
    .rx_ready   (rx_ready),
    .idle_flag  (idle_flag),
    .rx_irq     (rx_irq)
);

// File: tb/mpx_mute_ctrl_bench.sv
`timescale 1ns/1ps
module mpx_mute_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       idle_det = 1'b0;
    logic       mute_wr = 1'b0;
    logic       mute_wdata = 1'b0;
    logic       wake_sel = 1'b0;
    logic [3:0] node_addr = '0;
    logic       data_read = 1'b0;
    logic       idle_ack = 1'b0;
    logic       irq_en = 1'b0;
    logic       mute;
    logic       rx_ready;
    logic [7:0] rx_data;
    logic       idle_flag;
    logic       rx_irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    mpx_mute_ctrl u_mpx_mute_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .idle_det(idle_det), .mute_wr(mute_wr), .mute_wdata(mute_wdata),
        .wake_sel(wake_sel), .node_addr(node_addr), .data_read(data_read),
        .idle_ack(idle_ack), .irq_en(irq_en), .mute(mute),
        .rx_ready(rx_ready), .rx_data(rx_data), .idle_flag(idle_flag),
        .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one edge; outputs sampled and inputs changed 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0;
    endtask

    task automatic send_idle();
        idle_det = 1'b1; tick(); idle_det = 1'b0;
    endtask

    task automatic sw_mute(input logic v);
        mute_wr = 1'b1; mute_wdata = v; tick(); mute_wr = 1'b0;
    endtask

    task automatic host_read();
        data_read = 1'b1; tick(); data_read = 1'b0;
    endtask

    task automatic host_ack();
        idle_ack = 1'b1; tick(); idle_ack = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 mute", mute, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 idle_flag", idle_flag, 0);
        chk("R1 rx_irq", rx_irq, 0);

        // R5 R12 R11: every byte delivered unmuted in idle-line mode
        irq_en = 1'b1;
        for (int b = 0; b < 256; b++) begin
            send_byte(8'(b));
            chk("R5 ready", rx_ready, 1);
            chk("R12 data", rx_data, b);
            chk("R11 irq", rx_irq, 1);
            host_read();
            chk("R5 cleared", rx_ready, 0);
            chk("R11 irq low", rx_irq, 0);
        end

        // R5 new byte wins over a read in the same cycle
        send_byte(8'h11);
        data_read = 1'b1; rx_valid = 1'b1; rx_byte = 8'h22; tick();
        data_read = 1'b0; rx_valid = 1'b0;
        chk("R5 set wins", rx_ready, 1);
        chk("R5 set wins data", rx_data, 8'h22);

        // R2 R3: mute with a pending flag; irq held, flag kept
        sw_mute(1'b1);
        chk("R2 mute set", mute, 1);
        chk("R3 irq held", rx_irq, 0);
        chk("R3 flag kept", rx_ready, 1);
        // R9 idle-line mode muted: bytes dropped
        send_byte(8'h5A);
        send_byte(8'hC3);
        chk("R9 data kept", rx_data, 8'h22);
        host_read();
        send_byte(8'h7E);
        chk("R3 no ready while muted", rx_ready, 0);
        // R4 idle wake without idle flag
        send_idle();
        chk("R4 woke", mute, 0);
        chk("R4 no idle flag", idle_flag, 0);

        // R6 idle flag when unmuted
        send_idle();
        chk("R6 idle set", idle_flag, 1);
        chk("R11 irq idle", rx_irq, 1);
        host_ack();
        chk("R6 idle cleared", idle_flag, 0);

        // R2 software clear
        sw_mute(1'b1);
        sw_mute(1'b0);
        chk("R2 mute cleared", mute, 0);

        // R10 hardware wake beats software write of 1
        sw_mute(1'b1);
        idle_det = 1'b1; mute_wr = 1'b1; mute_wdata = 1'b1; tick();
        idle_det = 1'b0; mute_wr = 1'b0;
        chk("R10 hw wins", mute, 0);

        // R7 R8: sweep node address against received nibble, starting muted
        wake_sel = 1'b1;
        for (int n = 0; n < 16; n++) begin
            for (int k = 0; k < 16; k++) begin
                logic [7:0] b;
                b = 8'h80 | 8'(((n + k) % 8) << 4) | 8'(k);
                node_addr = 4'(n);
                sw_mute(1'b1);
                send_byte(b);
                chk("R7 R8 mute", mute, (k == n) ? 0 : 1);
                chk("R7 R8 ready", rx_ready, (k == n) ? 1 : 0);
                if (k == n) chk("R8 data", rx_data, b);
                host_read();
                sw_mute(1'b0);
            end
        end

        // R7 mismatch while unmuted mutes; R9 data bytes dropped
        node_addr = 4'h6;
        send_byte(8'h83);
        chk("R7 unmuted mismatch", mute, 1);
        chk("R7 not delivered", rx_ready, 0);
        send_byte(8'h35);
        chk("R9 addr-mode data dropped", rx_ready, 0);
        chk("R9 still muted", mute, 1);
        send_idle();
        chk("R3 idle ignored muted", idle_flag, 0);
        chk("R3 addr mode stays muted", mute, 1);
        // R8 match wakes; following data delivered
        send_byte(8'hF6);
        chk("R8 wake", mute, 0);
        chk("R8 data", rx_data, 8'hF6);
        host_read();
        send_byte(8'h35);
        chk("R8 data after wake", rx_data, 8'h35);
        // R8 matching address while unmuted delivered
        host_read();
        send_byte(8'h96);
        chk("R8 unmuted match", rx_ready, 1);
        chk("R8 unmuted match mute", mute, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule